// File: doc/BRIEF.md
# Floating-Point Divide Special-Case Resolver

This block sits in front of the mantissa divider of a floating-point unit and contains no state. Each operand arrives already classified as zero, normal, infinity, quiet NaN or signalling NaN, together with its sign. The resolver decides in the same cycle whether the quotient follows directly from the operand classes or must come from the mantissa datapath. It reports the class and sign of the result, and which operand (if any) the downstream mux should forward unchanged. It also raises one-shot exception indications for the three invalid-operation causes and for division by zero.

Because division is not commutative, the rules are applied with a fixed precedence. NaN operands are checked first, then an infinite dividend, then a zero dividend, then an infinite divisor, then a zero divisor. A pair of finite nonzero operands falls through to the datapath. Only the first rule that matches takes effect. A generated NaN uses a parameterised sign and payload.

Class code encoding used on every class port: 0 = zero, 1 = normal, 2 = infinity, 3 = quiet NaN, 4 = signalling NaN. Codes 5 to 7 are reserved and are resolved as signalling NaN. Pass-select encoding: 0 = no operand, 1 = dividend, 2 = divisor.

Top module: `fdiv_special`

## Requirements
- R1: If either operand is a NaN (code 3 or 4), the result forwards a NaN operand: its pass select, class and sign equal that operand's. If only one operand is a NaN, that operand is forwarded. If exactly one operand is signalling, that one is forwarded. If both are NaNs of the same kind, the divisor is forwarded (pass select 2).
- R2: `inv_snan_o` is 1 exactly when at least one operand is a signalling NaN (code 4), and 0 otherwise.
- R3: Infinity divided by infinity, with any signs, gives a generated NaN: class 3, sign `DNAN_SIGN`, payload `DNAN_PAYLOAD`, pass select 0. It raises `inv_inf_inf_o`.
- R4: Infinity divided by a normal number or by zero forwards the dividend: pass select 1, class 2, and the dividend's sign.
- R5: Zero divided by zero, with any signs, gives the generated NaN (class 3, sign `DNAN_SIGN`, payload `DNAN_PAYLOAD`, pass select 0) and raises `inv_zero_zero_o`.
- R6: Zero divided by a normal number or by infinity forwards the dividend: pass select 1, class 0, and the dividend's sign.
- R7: A normal number divided by infinity gives class 0, with sign equal to the XOR of the operand signs and pass select 0.
- R8: A normal number divided by zero gives class 2, with sign equal to the XOR of the operand signs. It raises `div_zero_o`, and this is the only case that raises it.
- R9: A normal number divided by a normal number sets `use_dp_o` with class 1 and sign equal to the XOR of the operand signs. `use_dp_o` is 0 for every other operand pair.
- R10: At most one of the four exception outputs is 1 for any input. `payload_o` is zero unless a NaN is generated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dvd_cls_i | input | CLS_W | Dividend class code |
| dvd_sign_i | input | 1 | Dividend sign |
| dvs_cls_i | input | CLS_W | Divisor class code |
| dvs_sign_i | input | 1 | Divisor sign |
| res_cls_o | output | CLS_W | Result class code |
| res_sign_o | output | 1 | Result sign |
| pass_sel_o | output | 2 | Operand to forward (0 none, 1 dividend, 2 divisor) |
| use_dp_o | output | 1 | Take the quotient from the mantissa datapath |
| payload_o | output | PAYLOAD_W | Payload of a generated NaN, else zero |
| inv_snan_o | output | 1 | Invalid: signalling NaN operand |
| inv_inf_inf_o | output | 1 | Invalid: infinity divided by infinity |
| inv_zero_zero_o | output | 1 | Invalid: zero divided by zero |
| div_zero_o | output | 1 | Finite nonzero divided by zero |

## Verification
The bench walks the class pairs that separate adjacent precedence levels. Inf/inf against inf/zero tells the generated-NaN path from dividend forwarding. Zero/zero against zero/inf does the same for a zero dividend. Normal/inf, normal/zero and normal/normal show whether the divisor rules fire only after both dividend rules have been ruled out. Each NaN pairing (one quiet, one signalling in either position, both quiet, both signalling, NaN against a number) shows which operand is forwarded, and sign sweeps over the XOR cases show that the sign comes from the right rule.

// File: rtl/fdiv_sc_pkg.sv
package fdiv_sc_pkg;
   typedef enum logic [2:0] {
      FC_ZERO = 3'd0,
      FC_NORM = 3'd1,
      FC_INF  = 3'd2,
      FC_QNAN = 3'd3,
      FC_SNAN = 3'd4
   } fcls_e;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DVD  = 2'd1,
      SEL_DVS  = 2'd2
   } psel_e;

   // one-hot view of an operand class
   typedef struct packed {
      logic zero;
      logic norm;
      logic inf;
      logic qnan;
      logic snan;
   } cls_oh_t;
endpackage

// File: rtl/fdiv_sc_decode.sv
module fdiv_sc_decode
   import fdiv_sc_pkg::*;
#(
   parameter int CLS_W = 3
) (
   input  logic [CLS_W-1:0] cls_i,
   output cls_oh_t          oh_o
);
   localparam int HI_W = (CLS_W > 3) ? CLS_W - 3 : 1;

   logic high_set;

   generate
      if (CLS_W > 3) begin : g_wide
         assign high_set = |cls_i[CLS_W-1 -: HI_W];
      end else begin : g_exact
         assign high_set = 1'b0;
      end
   endgenerate

   always_comb begin
      oh_o = '0;
      if (high_set) begin
         oh_o.snan = 1'b1;
      end else begin
         case (cls_i[2:0])
            FC_ZERO: oh_o.zero = 1'b1;
            FC_NORM: oh_o.norm = 1'b1;
            FC_INF:  oh_o.inf  = 1'b1;
            FC_QNAN: oh_o.qnan = 1'b1;
            default: oh_o.snan = 1'b1; // signalling and reserved codes
         endcase
      end
   end
endmodule

// File: rtl/fdiv_sc_nanpick.sv
module fdiv_sc_nanpick
   import fdiv_sc_pkg::*;
#(
   parameter bit TIE_TO_DIVISOR = 1'b1
) (
   input  cls_oh_t     dvd_i,
   input  cls_oh_t     dvs_i,
   output logic        any_nan_o,
   output logic        any_snan_o,
   output logic [1:0]  sel_o
);
   logic dvd_nan, dvs_nan;
   logic [1:0] tie_sel;

   assign dvd_nan    = dvd_i.qnan | dvd_i.snan;
   assign dvs_nan    = dvs_i.qnan | dvs_i.snan;
   assign any_nan_o  = dvd_nan | dvs_nan;
   assign any_snan_o = dvd_i.snan | dvs_i.snan;

   generate
      if (TIE_TO_DIVISOR) begin : g_tie_dvs
         assign tie_sel = SEL_DVS;
      end else begin : g_tie_dvd
         assign tie_sel = SEL_DVD;
      end
   endgenerate

   always_comb begin
      if (!any_nan_o)                      sel_o = SEL_NONE;
      else if (dvd_nan && !dvs_nan)        sel_o = SEL_DVD;
      else if (dvs_nan && !dvd_nan)        sel_o = SEL_DVS;
      else if (dvd_i.snan && !dvs_i.snan)  sel_o = SEL_DVD;
      else if (dvs_i.snan && !dvd_i.snan)  sel_o = SEL_DVS;
      else                                 sel_o = tie_sel;
   end
endmodule

// File: rtl/fdiv_sc_rules.sv
module fdiv_sc_rules
   import fdiv_sc_pkg::*;
#(
   parameter int CLS_W     = 3,
   parameter int PAYLOAD_W = 8,
   parameter bit DNAN_SIGN = 1'b0,
   parameter logic [PAYLOAD_W-1:0] DNAN_PAYLOAD = '0
) (
   input  cls_oh_t                dvd_i,
   input  cls_oh_t                dvs_i,
   input  logic                   dvd_sign_i,
   input  logic                   dvs_sign_i,
   input  logic                   any_nan_i,
   input  logic [1:0]             nan_sel_i,
   output logic [CLS_W-1:0]       cls_o,
   output logic                   sign_o,
   output logic [1:0]             sel_o,
   output logic                   use_dp_o,
   output logic [PAYLOAD_W-1:0]   payload_o,
   output logic                   inf_inf_o,
   output logic                   zero_zero_o,
   output logic                   div_zero_o
);
   logic       sgn_x;
   logic       nan_is_snan;
   logic       nan_sign;

   assign sgn_x       = dvd_sign_i ^ dvs_sign_i;
   assign nan_is_snan = (nan_sel_i == SEL_DVD) ? dvd_i.snan : dvs_i.snan;
   assign nan_sign    = (nan_sel_i == SEL_DVD) ? dvd_sign_i : dvs_sign_i;

   function automatic logic [CLS_W-1:0] code(fcls_e c);
      return CLS_W'(c);
   endfunction

   always_comb begin
      cls_o       = code(FC_NORM);
      sign_o      = sgn_x;
      sel_o       = SEL_NONE;
      use_dp_o    = 1'b0;
      payload_o   = '0;
      inf_inf_o   = 1'b0;
      zero_zero_o = 1'b0;
      div_zero_o  = 1'b0;
      if (any_nan_i) begin
         sel_o  = nan_sel_i;
         cls_o  = nan_is_snan ? code(FC_SNAN) : code(FC_QNAN);
         sign_o = nan_sign;
      end else if (dvd_i.inf) begin
         if (dvs_i.inf) begin
            cls_o     = code(FC_QNAN);
            sign_o    = DNAN_SIGN;
            payload_o = DNAN_PAYLOAD;
            inf_inf_o = 1'b1;
         end else begin
            cls_o  = code(FC_INF);
            sign_o = dvd_sign_i;
            sel_o  = SEL_DVD;
         end
      end else if (dvd_i.zero) begin
         if (dvs_i.zero) begin
            cls_o       = code(FC_QNAN);
            sign_o      = DNAN_SIGN;
            payload_o   = DNAN_PAYLOAD;
            zero_zero_o = 1'b1;
         end else begin
            cls_o  = code(FC_ZERO);
            sign_o = dvd_sign_i;
            sel_o  = SEL_DVD;
         end
      end else if (dvs_i.inf) begin
         cls_o = code(FC_ZERO);
      end else if (dvs_i.zero) begin
         cls_o      = code(FC_INF);
         div_zero_o = 1'b1;
      end else begin
         cls_o    = code(FC_NORM);
         use_dp_o = 1'b1;
      end
   end
endmodule

// File: rtl/fdiv_special.sv
module fdiv_special
   import fdiv_sc_pkg::*;
#(
   parameter int CLS_W          = 3,
   parameter int PAYLOAD_W      = 8,
   parameter bit DNAN_SIGN      = 1'b0,
   parameter logic [PAYLOAD_W-1:0] DNAN_PAYLOAD = PAYLOAD_W'(1) << (PAYLOAD_W - 1),
   parameter bit TIE_TO_DIVISOR = 1'b1
) (
   input  logic [CLS_W-1:0]     dvd_cls_i,
   input  logic                 dvd_sign_i,
   input  logic [CLS_W-1:0]     dvs_cls_i,
   input  logic                 dvs_sign_i,
   output logic [CLS_W-1:0]     res_cls_o,
   output logic                 res_sign_o,
   output logic [1:0]           pass_sel_o,
   output logic                 use_dp_o,
   output logic [PAYLOAD_W-1:0] payload_o,
   output logic                 inv_snan_o,
   output logic                 inv_inf_inf_o,
   output logic                 inv_zero_zero_o,
   output logic                 div_zero_o
);
   localparam int N_OPS = 2;

   generate
      if (CLS_W < 3) begin : g_bad_cls
         $error("fdiv_special: CLS_W must be at least 3");
      end
      if (PAYLOAD_W < 1) begin : g_bad_pay
         $error("fdiv_special: PAYLOAD_W must be at least 1");
      end
   endgenerate

   logic [N_OPS-1:0][CLS_W-1:0] cls_in;
   cls_oh_t                     op_oh [N_OPS];
   logic                        any_nan;
   logic [1:0]                  nan_sel;

   assign cls_in[0] = dvd_cls_i;
   assign cls_in[1] = dvs_cls_i;

   generate
      for (genvar g = 0; g < N_OPS; g++) begin : g_dec
         fdiv_sc_decode #(.CLS_W(CLS_W)) i_dec (
            .cls_i (cls_in[g]),
            .oh_o  (op_oh[g])
         );
      end
   endgenerate

   fdiv_sc_nanpick #(.TIE_TO_DIVISOR(TIE_TO_DIVISOR)) i_nan (
      .dvd_i      (op_oh[0]),
      .dvs_i      (op_oh[1]),
      .any_nan_o  (any_nan),
      .any_snan_o (inv_snan_o),
      .sel_o      (nan_sel)
   );

   fdiv_sc_rules #(
      .CLS_W        (CLS_W),
      .PAYLOAD_W    (PAYLOAD_W),
      .DNAN_SIGN    (DNAN_SIGN),
      .DNAN_PAYLOAD (DNAN_PAYLOAD)
   ) i_rules (
      .dvd_i       (op_oh[0]),
      .dvs_i       (op_oh[1]),
      .dvd_sign_i  (dvd_sign_i),
      .dvs_sign_i  (dvs_sign_i),
      .any_nan_i   (any_nan),
      .nan_sel_i   (nan_sel),
      .cls_o       (res_cls_o),
      .sign_o      (res_sign_o),
      .sel_o       (pass_sel_o),
      .use_dp_o    (use_dp_o),
      .payload_o   (payload_o),
      .inf_inf_o   (inv_inf_inf_o),
      .zero_zero_o (inv_zero_zero_o),
      .div_zero_o  (div_zero_o)
   );
endmodule

// File: rtl/fdiv_special_chk.sv
module fdiv_special_chk #(
   parameter int CLS_W     = 3,
   parameter int PAYLOAD_W = 8
) (
   input logic [CLS_W-1:0]     dvd_cls_i,
   input logic [CLS_W-1:0]     dvs_cls_i,
   input logic [CLS_W-1:0]     res_cls_o,
   input logic [1:0]           pass_sel_o,
   input logic                 use_dp_o,
   input logic [PAYLOAD_W-1:0] payload_o,
   input logic                 inv_snan_o,
   input logic                 inv_inf_inf_o,
   input logic                 inv_zero_zero_o,
   input logic                 div_zero_o
);
   logic a_nan, b_nan, a_sn, b_sn;
   assign a_sn  = (dvd_cls_i >= CLS_W'(4));
   assign b_sn  = (dvs_cls_i >= CLS_W'(4));
   assign a_nan = a_sn || (dvd_cls_i == CLS_W'(3));
   assign b_nan = b_sn || (dvs_cls_i == CLS_W'(3));

   always_comb begin
      AST_NAN_FORWARDED: assert (!(a_nan || b_nan) || (pass_sel_o != 2'd0)); // R1
      AST_SNAN_FLAG: assert (inv_snan_o == (a_sn || b_sn)); // R2
      AST_INF_INF_CASE: assert (!inv_inf_inf_o || (dvd_cls_i == CLS_W'(2) && dvs_cls_i == CLS_W'(2))); // R3
      AST_ZERO_ZERO_CASE: assert (!inv_zero_zero_o || (dvd_cls_i == '0 && dvs_cls_i == '0)); // R5
      AST_DZ_CASE: assert (!div_zero_o || (dvd_cls_i == CLS_W'(1) && dvs_cls_i == '0)); // R8
      AST_DP_ONLY_NORM: assert (!use_dp_o || (dvd_cls_i == CLS_W'(1) && dvs_cls_i == CLS_W'(1) && res_cls_o == CLS_W'(1))); // R9
      AST_FLAGS_EXCL: assert ($countones({inv_snan_o, inv_inf_inf_o, inv_zero_zero_o, div_zero_o}) <= 1); // R10
      AST_PAYLOAD_QUIET: assert ((payload_o == '0) || inv_inf_inf_o || inv_zero_zero_o); // R10
   end
endmodule

bind fdiv_special fdiv_special_chk #(.CLS_W(CLS_W), .PAYLOAD_W(PAYLOAD_W)) i_chk (
   .dvd_cls_i       (dvd_cls_i),
   .dvs_cls_i       (dvs_cls_i),
   .res_cls_o       (res_cls_o),
   .pass_sel_o      (pass_sel_o),
   .use_dp_o        (use_dp_o),
   .payload_o       (payload_o),
   .inv_snan_o      (inv_snan_o),
   .inv_inf_inf_o   (inv_inf_inf_o),
   .inv_zero_zero_o (inv_zero_zero_o),
   .div_zero_o      (div_zero_o)
);

// File: tb/test_fdiv_special.sv
module test_fdiv_special;
   localparam int CW = 3;
   localparam int PW = 8;
   localparam int Z = 0, N = 1, I = 2, Q = 3, S = 4;
   localparam int DPAY = 8'h80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [CW-1:0] a_cls, b_cls, r_cls;
   logic a_sg, b_sg, r_sg, dp, f_sn, f_ii, f_zz, f_dz;
   logic [1:0] sel;
   logic [PW-1:0] pay;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   fdiv_special i_fdiv_special (
      .dvd_cls_i(a_cls), .dvd_sign_i(a_sg), .dvs_cls_i(b_cls), .dvs_sign_i(b_sg),
      .res_cls_o(r_cls), .res_sign_o(r_sg), .pass_sel_o(sel), .use_dp_o(dp),
      .payload_o(pay), .inv_snan_o(f_sn), .inv_inf_inf_o(f_ii),
      .inv_zero_zero_o(f_zz), .div_zero_o(f_dz)
   );

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic apply(int ac, bit as, int bc, bit bs);
      @(posedge clk);
      a_cls = CW'(ac); a_sg = as; b_cls = CW'(bc); b_sg = bs;
      @(negedge clk);
   endtask

   // expected: class, sign, select, datapath, flags {snan,ii,zz,dz}, payload
   task automatic expect_all(string tag, int c, bit s, int sl, bit d, int flg, int p);
      chk(tag, "class", int'(r_cls), c);
      chk(tag, "sign", int'(r_sg), int'(s));
      chk(tag, "sel", int'(sel), sl);
      chk(tag, "use_dp", int'(dp), int'(d));
      chk(tag, "flags", int'({f_sn, f_ii, f_zz, f_dz}), flg);
      chk(tag, "payload", int'(pay), p);
   endtask

   task automatic t_reset;
      apply(Z, 0, Z, 0);
      expect_all("R5", Q, 0, 0, 0, 4'b0010, DPAY);
   endtask

   task automatic t_nan;
      apply(Q, 1, N, 0);  expect_all("R1", Q, 1, 1, 0, 4'b0000, 0);
      apply(I, 0, Q, 1);  expect_all("R1", Q, 1, 2, 0, 4'b0000, 0);
      apply(Q, 0, S, 1);  expect_all("R1", S, 1, 2, 0, 4'b1000, 0);
      apply(S, 1, Q, 0);  expect_all("R1", S, 1, 1, 0, 4'b1000, 0);
      apply(Q, 0, Q, 1);  expect_all("R1", Q, 1, 2, 0, 4'b0000, 0);
      apply(S, 0, S, 1);  expect_all("R2", S, 1, 2, 0, 4'b1000, 0);
      apply(Z, 0, S, 0);  expect_all("R2", S, 0, 2, 0, 4'b1000, 0);
      apply(S, 1, I, 1);  expect_all("R2", S, 1, 1, 0, 4'b1000, 0);
   endtask

   task automatic t_inf_dividend;
      apply(I, 1, I, 0);  expect_all("R3", Q, 0, 0, 0, 4'b0100, DPAY);
      apply(I, 0, I, 0);  expect_all("R3", Q, 0, 0, 0, 4'b0100, DPAY);
      apply(I, 1, N, 0);  expect_all("R4", I, 1, 1, 0, 4'b0000, 0);
      apply(I, 0, Z, 1);  expect_all("R4", I, 0, 1, 0, 4'b0000, 0);
   endtask

   task automatic t_zero_dividend;
      apply(Z, 1, Z, 1);  expect_all("R5", Q, 0, 0, 0, 4'b0010, DPAY);
      apply(Z, 1, N, 0);  expect_all("R6", Z, 1, 1, 0, 4'b0000, 0);
      apply(Z, 0, I, 1);  expect_all("R6", Z, 0, 1, 0, 4'b0000, 0);
   endtask

   task automatic t_norm_dividend;
      for (int k = 0; k < 4; k++) begin
         bit sa = k[1];
         bit sb = k[0];
         apply(N, sa, I, sb); expect_all("R7", Z, sa ^ sb, 0, 0, 4'b0000, 0);
         apply(N, sa, Z, sb); expect_all("R8", I, sa ^ sb, 0, 0, 4'b0001, 0);
         apply(N, sa, N, sb); expect_all("R9", N, sa ^ sb, 0, 1, 4'b0000, 0);
      end
   endtask

   task automatic t_exclusive;
      // R10: every pair leaves at most one flag set and no payload outside NaN generation
      for (int a = 0; a < 5; a++) begin
         for (int b = 0; b < 5; b++) begin
            bit gen;
            apply(a, 1, b, 0);
            gen = (a == I && b == I) || (a == Z && b == Z);
            chk("R10", "flag_count", $countones({f_sn, f_ii, f_zz, f_dz}) <= 1, 1);
            chk("R10", "payload", int'(pay), gen ? DPAY : 0);
            chk("R9", "use_dp", int'(dp), (a == N && b == N) ? 1 : 0);
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      a_cls = '0; b_cls = '0; a_sg = 1'b0; b_sg = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset();
      t_nan();
      t_inf_dividend();
      t_zero_dividend();
      t_norm_dividend();
      t_exclusive();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule